// File: doc/BRIEF.md
# Multi-Driver Strength Resolution Net

This block stands for one shared net with a fixed number of drivers, three by default. Each driver presents a four-state value and a three-bit strength code. A mode select picks how the drivers combine:

- **Strength arbitration.** The strongest drivers set the net.
- **Wired logic.** The drivers are ANDed or ORed.
- **Pull default.** Strength arbitration, but an undriven net reads 0 or 1.
- **Capacitive hold.** The net remembers the last driven value while every driver is off.

The outputs are the resolved value and its strength. The path from the drivers to the net is combinational. The only state is one value register, which capacitive hold uses. There is no data stream through the block, so every pin is a plain control or level pin with no handshake.

Top module: `strength_net`

## Requirements
- R1: Value codes are 0 = logic 0, 1 = logic 1, 2 = z, 3 = x. Strength codes run from weakest to strongest: 0 highz, 1 small, 2 medium, 3 weak, 4 large, 5 pull, 6 strong, 7 supply. A driver is active only when its value is not z and its strength is not 0.
- R2: In arbitration modes, the net takes the value held by all active drivers at the highest strength present, and reports that strength.
- R3: In plain tri mode (mode 0), a net with no active driver reads z at strength 0.
- R4: Two active drivers at the winning strength with opposite values give x at that strength. So does any x driver at the winning strength.
- R5: In wired-AND mode (mode 1), any active 0 gives 0. Otherwise any active x gives x. Otherwise the net is 1. The reported strength is the highest active strength. With no active driver the net reads z at strength 0.
- R6: Wired-OR mode (mode 2) works the same way, with 1 dominating in place of 0.
- R7: In pulldown mode (mode 3) and pullup mode (mode 4), an undriven net reads 0 or 1 at strength 5 (pull). When driven, these modes behave as R2 and R4.
- R8: In capacitive mode (mode 5), a driven net resolves as R2 and R4. The resolved value is stored on the next rising clock edge.
- R9: In capacitive mode with no active driver, the net shows the stored value at the strength named by `charge_sel`. Codes 1, 2 and 4 give small, medium and large. Any other code gives medium.
- R10: Reset sets the stored value to x. The stored value changes only in capacitive mode while the net is driven.
- R11: Mode codes 6 and 7 behave as plain tri mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the stored-charge register |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_val | input | 2*NDRV | Value code per driver, driver i at bits [2i+1:2i] |
| drv_str | input | 3*NDRV | Strength code per driver, driver i at bits [3i+2:3i] |
| net_mode | input | 3 | Resolution mode select |
| charge_sel | input | 3 | Strength reported while charge is held |
| net_val | output | 2 | Resolved value code |
| net_str | output | 3 | Resolved strength code |

## Verification
The bench builds the block with its default of three drivers. With three drivers every value and strength combination of the drivers, 32768 patterns, can be swept through each combinational mode and compared against an arithmetic model. Three drivers are enough to show a weak pair outvoted by one stronger driver, ties among several strongest drivers, and x mixed with dominating wired values. The capacitive mode is exercised by a long pseudo-random clocked sequence that moves between driven and undriven states. This sequence also cycles every `charge_sel` code and enters from other modes, so the stored value must survive mode changes.

// File: rtl/sn_pkg.sv
package sn_pkg;
  localparam int VW = 2;
  localparam int SW = 3;

  localparam logic [VW-1:0] V_ZERO = 2'd0;
  localparam logic [VW-1:0] V_ONE  = 2'd1;
  localparam logic [VW-1:0] V_HIZ  = 2'd2;
  localparam logic [VW-1:0] V_UNK  = 2'd3;

  localparam logic [SW-1:0] S_HIGHZ  = 3'd0;
  localparam logic [SW-1:0] S_SMALL  = 3'd1;
  localparam logic [SW-1:0] S_MEDIUM = 3'd2;
  localparam logic [SW-1:0] S_LARGE  = 3'd4;
  localparam logic [SW-1:0] S_PULL   = 3'd5;

  typedef enum logic [2:0] {
    M_TRI    = 3'd0,
    M_WAND   = 3'd1,
    M_WOR    = 3'd2,
    M_TRI0   = 3'd3,
    M_TRI1   = 3'd4,
    M_TRIREG = 3'd5
  } net_mode_e;
endpackage

// File: rtl/sn_strength_arb.sv
module sn_strength_arb
  import sn_pkg::*;
#(
  parameter int NDRV = 3
) (
  input  logic [VW*NDRV-1:0] drv_val,
  input  logic [SW*NDRV-1:0] drv_str,
  output logic [VW-1:0]      win_val,
  output logic [SW-1:0]      win_str,
  output logic               any_act
);
  logic [SW-1:0] top;
  logic          seen0, seen1, seenx;

  always_comb begin
    top     = S_HIGHZ;
    any_act = 1'b0;
    for (int i = 0; i < NDRV; i++) begin
      if (drv_val[VW*i +: VW] != V_HIZ && drv_str[SW*i +: SW] != S_HIGHZ) begin
        any_act = 1'b1;
        if (drv_str[SW*i +: SW] > top) top = drv_str[SW*i +: SW];
      end
    end
    seen0 = 1'b0;
    seen1 = 1'b0;
    seenx = 1'b0;
    for (int i = 0; i < NDRV; i++) begin
      if (drv_val[VW*i +: VW] != V_HIZ && drv_str[SW*i +: SW] != S_HIGHZ &&
          drv_str[SW*i +: SW] == top) begin
        case (drv_val[VW*i +: VW])
          V_ZERO:  seen0 = 1'b1;
          V_ONE:   seen1 = 1'b1;
          default: seenx = 1'b1;
        endcase
      end
    end
    if (!any_act) begin
      win_val = V_HIZ;
      win_str = S_HIGHZ;
    end else begin
      win_str = top;
      if (seenx || (seen0 && seen1)) win_val = V_UNK;
      else if (seen1)                win_val = V_ONE;
      else                           win_val = V_ZERO;
    end
  end
endmodule

// File: rtl/sn_wired.sv
module sn_wired
  import sn_pkg::*;
#(
  parameter int NDRV   = 3,
  parameter bit IS_AND = 1'b1
) (
  input  logic [VW*NDRV-1:0] drv_val,
  input  logic [SW*NDRV-1:0] drv_str,
  output logic [VW-1:0]      res_val,
  output logic [SW-1:0]      res_str
);
  localparam logic [VW-1:0] DOM  = IS_AND ? V_ZERO : V_ONE;
  localparam logic [VW-1:0] PASS = IS_AND ? V_ONE  : V_ZERO;

  logic          act, has_dom, has_x;
  logic [SW-1:0] top;

  always_comb begin
    act     = 1'b0;
    has_dom = 1'b0;
    has_x   = 1'b0;
    top     = S_HIGHZ;
    for (int i = 0; i < NDRV; i++) begin
      if (drv_val[VW*i +: VW] != V_HIZ && drv_str[SW*i +: SW] != S_HIGHZ) begin
        act = 1'b1;
        if (drv_str[SW*i +: SW] > top) top = drv_str[SW*i +: SW];
        if (drv_val[VW*i +: VW] == DOM)   has_dom = 1'b1;
        if (drv_val[VW*i +: VW] == V_UNK) has_x   = 1'b1;
      end
    end
    if (!act) begin
      res_val = V_HIZ;
      res_str = S_HIGHZ;
    end else begin
      res_str = top;
      if (has_dom)    res_val = DOM;
      else if (has_x) res_val = V_UNK;
      else            res_val = PASS;
    end
  end
endmodule

// File: rtl/sn_charge_cell.sv
module sn_charge_cell
  import sn_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [VW-1:0] din,
  input  logic [2:0]    charge_sel,
  output logic [VW-1:0] q,
  output logic [SW-1:0] q_str
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= V_UNK;
    else if (load) q <= din;
  end

  always_comb begin
    case (charge_sel)
      3'd1:    q_str = S_SMALL;
      3'd4:    q_str = S_LARGE;
      default: q_str = S_MEDIUM;
    endcase
  end

  // R10: first edge out of reset still shows the reset value x
  a_r10_reset_unknown: assert property (@(posedge clk) $rose(rst_n) |-> q == V_UNK);
  // R10: stored value only moves when a load was requested
  a_r10_hold_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/strength_net.sv
module strength_net
  import sn_pkg::*;
#(
  parameter int NDRV = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*NDRV-1:0]   drv_val,
  input  logic [3*NDRV-1:0]   drv_str,
  input  logic [2:0]          net_mode,
  input  logic [2:0]          charge_sel,
  output logic [1:0]          net_val,
  output logic [2:0]          net_str
);
  logic [VW-1:0] arb_val, q_val;
  logic [SW-1:0] arb_str, q_str;
  logic          any_act;
  logic [VW-1:0] w_val [2];
  logic [SW-1:0] w_str [2];
  logic          load;

  sn_strength_arb #(.NDRV(NDRV)) i_arb (
    .drv_val(drv_val), .drv_str(drv_str),
    .win_val(arb_val), .win_str(arb_str), .any_act(any_act)
  );

  for (genvar g = 0; g < 2; g++) begin : g_wired
    sn_wired #(.NDRV(NDRV), .IS_AND(g == 0)) i_wired (
      .drv_val(drv_val), .drv_str(drv_str),
      .res_val(w_val[g]), .res_str(w_str[g])
    );
  end

  assign load = (net_mode == M_TRIREG) && any_act;

  sn_charge_cell i_cell (
    .clk(clk), .rst_n(rst_n), .load(load), .din(arb_val),
    .charge_sel(charge_sel), .q(q_val), .q_str(q_str)
  );

  always_comb begin
    net_val = arb_val;
    net_str = arb_str;
    case (net_mode)
      M_WAND: begin net_val = w_val[0]; net_str = w_str[0]; end
      M_WOR:  begin net_val = w_val[1]; net_str = w_str[1]; end
      M_TRI0: if (!any_act) begin net_val = V_ZERO; net_str = S_PULL; end
      M_TRI1: if (!any_act) begin net_val = V_ONE;  net_str = S_PULL; end
      M_TRIREG: if (!any_act) begin net_val = q_val; net_str = q_str; end
      default: ;
    endcase
  end

  a_r3_tri_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (net_mode == M_TRI && !any_act) |-> (net_val == V_HIZ && net_str == S_HIGHZ));
  a_r7_pull_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (net_mode == M_TRI0 && !any_act) |-> (net_val == V_ZERO && net_str == S_PULL));
  a_r2_known_strong: assert property (@(posedge clk) disable iff (!rst_n)
    (net_val == V_ZERO || net_val == V_ONE) |-> net_str != S_HIGHZ);
  a_r9_charge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (net_mode == M_TRIREG && !any_act && $past(net_mode == M_TRIREG && !any_act))
      |-> $stable(net_val));
endmodule

// File: tb/test_strength_net.sv
`timescale 1ns/100ps
module test_strength_net;
  localparam int N = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [2*N-1:0] drv_val = '0;
  logic [3*N-1:0] drv_str = '0;
  logic [2:0]     net_mode = 3'd0;
  logic [2:0]     charge_sel = 3'd2;
  logic [1:0]     net_val;
  logic [2:0]     net_str;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;
  logic [1:0] stored = 2'd3;

  always #10 clk = ~clk;

  strength_net #(.NDRV(N)) i_strength_net (
    .clk(clk), .rst_n(rst_n), .drv_val(drv_val), .drv_str(drv_str),
    .net_mode(net_mode), .charge_sel(charge_sel),
    .net_val(net_val), .net_str(net_str)
  );

  // model of the requirements; returns {value, strength, active}
  function automatic logic [5:0] model(input logic [2*N-1:0] v, input logic [3*N-1:0] s,
                                       input logic [2:0] m, input logic [1:0] st,
                                       input logic [2:0] cs);
    logic act = 0, s0 = 0, s1 = 0, sx = 0, d0 = 0, d1 = 0;
    logic [2:0] top = 0, cstr;
    logic [1:0] av, rv;
    for (int i = 0; i < N; i++)
      if (v[2*i +: 2] != 2 && s[3*i +: 3] != 0) begin
        act = 1;
        if (s[3*i +: 3] > top) top = s[3*i +: 3];
        if (v[2*i +: 2] == 0) d0 = 1;
        if (v[2*i +: 2] == 1) d1 = 1;
      end
    for (int i = 0; i < N; i++)
      if (v[2*i +: 2] != 2 && s[3*i +: 3] == top && top != 0) begin
        if (v[2*i +: 2] == 0) s0 = 1;
        else if (v[2*i +: 2] == 1) s1 = 1;
        else sx = 1;
      end
    av = (sx || (s0 && s1)) ? 2'd3 : (s1 ? 2'd1 : 2'd0);
    cstr = (cs == 1 || cs == 4) ? cs : 3'd2;
    if (!act) begin
      case (m)
        3: return {2'd0, 3'd5, 1'b0};
        4: return {2'd1, 3'd5, 1'b0};
        5: return {st, cstr, 1'b0};
        default: return {2'd2, 3'd0, 1'b0};
      endcase
    end
    if (m == 1) begin
      rv = d0 ? 2'd0 : (sx || (act && !d1) || (d1 && (sx)) ? 2'd3 : 2'd1);
      rv = d0 ? 2'd0 : (has_x(v, s) ? 2'd3 : 2'd1);
      return {rv, top, 1'b1};
    end
    if (m == 2) begin
      rv = d1 ? 2'd1 : (has_x(v, s) ? 2'd3 : 2'd0);
      return {rv, top, 1'b1};
    end
    return {av, top, 1'b1};
  endfunction

  function automatic logic has_x(input logic [2*N-1:0] v, input logic [3*N-1:0] s);
    for (int i = 0; i < N; i++)
      if (v[2*i +: 2] == 3 && s[3*i +: 3] != 0) return 1'b1;
    return 1'b0;
  endfunction

  function automatic string req_of(input logic [2:0] m, input logic act);
    case (m)
      0: return act ? "R2/R4" : "R3";
      1: return "R5";
      2: return "R6";
      3, 4: return act ? "R2/R4" : "R7";
      5: return act ? "R8" : "R9/R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag);
    logic [5:0] e;
    e = model(drv_val, drv_str, net_mode, stored, charge_sel);
    vectors++;
    if (net_val !== e[5:4] || net_str !== e[3:1]) begin
      fails++;
      $display("FAIL %s %s mode=%0d val=%h str=%h: got %0d/%0d expected %0d/%0d",
               tag, req_of(net_mode, e[0]), net_mode, drv_val, drv_str,
               net_val, net_str, e[5:4], e[3:1]);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] lfsr;
    // reset state: capacitive mode, undriven, medium charge -> x at medium (R10, R9)
    net_mode = 3'd5;
    drv_val = {N{2'd2}};
    repeat (3) @(negedge clk);
    check("reset R10");
    rst_n = 1'b1;
    @(negedge clk);
    check("after reset R10");

    // exhaustive combinational sweep, modes 0..4 (R1..R7)
    for (int m = 0; m < 5; m++) begin
      net_mode = m[2:0];
      for (int p = 0; p < (1 << (5*N)); p++) begin
        for (int i = 0; i < N; i++) begin
          drv_val[2*i +: 2] = p[5*i +: 2];
          drv_str[3*i +: 3] = p[5*i+2 +: 3];
        end
        #0.5 check("sweep");
        #0.5;
      end
    end

    // modes 6 and 7 act as tri (R11)
    for (int m = 6; m < 8; m++) begin
      net_mode = m[2:0];
      for (int p = 0; p < 4096; p++) begin
        for (int i = 0; i < N; i++) begin
          drv_val[2*i +: 2] = p[4*i +: 2];
          drv_str[3*i +: 3] = {p[4*i+2 +: 2], p[i]};
        end
        #0.5 check("R11 sweep");
        #0.5;
      end
    end

    // clocked capacitive sequence (R8, R9, R10)
    lfsr = 16'hACE1;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      net_mode   = (lfsr[3:0] < 4'd11) ? 3'd5 : lfsr[6:4];
      charge_sel = lfsr[9:7];
      for (int i = 0; i < N; i++) begin
        // mostly undriven so holding is visible
        drv_val[2*i +: 2] = (lfsr[10+i] && lfsr[13]) ? lfsr[2*i +: 2] : 2'd2;
        drv_str[3*i +: 3] = lfsr[3*i+4 +: 3];
      end
      #5 check("R8/R9 seq");
      begin
        logic [5:0] e;
        e = model(drv_val, drv_str, net_mode, stored, charge_sel);
        if (net_mode == 3'd5 && e[0]) stored = e[5:4];
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule